// File: doc/BRIEF.md
# Selectable-Rate Bit Clock Generator

This block derives a serial bit-rate enable from a 1.024 MHz reference. The reference arrives as single-cycle tick strobes in the system clock domain, one strobe per reference period. There are two such strobes: one from an on-board oscillator and one from an external reference input. A single select input picks which of the two is counted, and the other is ignored.

A four-bit thermometer code on `rate_code` sets the division ratio. The number of consecutive set bits, counted upward from bit 0, is the divide exponent, so the ratio is 1, 2, 4, 8 or 16. This gives bit rates from 1.024 Mbit/s down to 64 kbit/s. A pattern that is not a thermometer code falls back to the slowest rate and raises `config_error`.

The block has two outputs:
- `rate_en`: a one-cycle enable for the downstream bit logic.
- `rate_clk`: a square wave at the bit rate.

The configuration inputs are meant to be static. Whenever the code or the source select changes, the divider restarts from zero through a short hold phase.

A two-state sequencer controls the divider:
- HOLD: the counter is cleared and reference ticks are ignored.
- RUN: ticks on the selected source advance the counter.

Its transitions are:
- Reset enters HOLD.
- HOLD moves to RUN on the first edge at which the configuration is the same as at the previous edge. It stays in HOLD while the configuration keeps changing.
- RUN moves to HOLD on any edge that sees a configuration change.

Top module: `rclk_rate_gen`

## Requirements
- R1: `rate_code` bit 0 is the first thermometer position. Codes 4'b0000, 4'b0001, 4'b0011, 4'b0111 and 4'b1111 divide the selected reference ticks by 1, 2, 4, 8 and 16 respectively.
- R2: With `use_int_ref` = 1 only `int_ref_tick` is counted; with `use_int_ref` = 0 only `ext_ref_tick` is counted. A tick on the unselected line changes neither output.
- R3: `rate_en` is high for exactly the one cycle after the clock edge that samples the N-th counted tick of a period, where N is the ratio. At no other time is it high.
- R4: For ratios above 1, after k counted ticks since the start of a period, `rate_clk` is high exactly when (k mod N) >= N/2. This gives a 50% duty cycle, with the falling edge in the same cycle as `rate_en`.
- R5: At ratio 1 (code 4'b0000), `rate_clk` is held high and `rate_en` follows every counted tick.
- R6: Any code other than the five in R1 divides by 16. Such a code sets `config_error` high from the cycle after the edge that samples it, and a valid code clears `config_error` with the same latency.
- R7: On a change of `rate_code` or `use_int_ref`, the edge that sees the change and the following edge both clear the counter and ignore ticks. The cycle after the change carries no `rate_en`, and the next `rate_en` follows N further counted ticks.
- R8: While `rst_n` is low, `rate_en` and `config_error` are low, the counter is zero (so `rate_clk` is low for any nonzero code), and the sequencer is in HOLD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| use_int_ref | input | 1 | 1 selects the internal reference ticks, 0 the external ones |
| int_ref_tick | input | 1 | One-cycle strobe per internal 1.024 MHz period |
| ext_ref_tick | input | 1 | One-cycle strobe per external 1.024 MHz period |
| rate_code | input | 4 | Thermometer rate selection |
| rate_en | output | 1 | One-cycle bit-rate enable |
| rate_clk | output | 1 | Divided square-wave clock |
| config_error | output | 1 | High while the rate code is not a thermometer code |

## Verification
The assertions check four relationships on every cycle:
- every `rate_en` is preceded by a tick on the selected source;
- no enable follows a configuration change;
- `config_error` tracks the validity of the previous code;
- `rate_clk` is low whenever an enable marks a period boundary, and high under the unity code.

Only the directed scenarios can show the rest. These are the exact period and duty pattern at each ratio, the fallback ratio for invalid codes, the rejection of ticks on the unselected line, and the full new period after a restart that coincides with a tick.

// File: rtl/rclk_pkg.sv
package rclk_pkg;

    // Sequencer states: HOLD clears the divider, RUN lets it count ticks.
    typedef enum logic {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_t;

endpackage

// File: rtl/rclk_decode.sv
module rclk_decode #(
    parameter int SEL_W = 4,
    parameter int EXP_W = $clog2(SEL_W + 1)
) (
    input  logic [SEL_W-1:0] code,
    output logic [EXP_W-1:0] exponent,
    output logic             invalid
);

    logic [EXP_W-1:0] ones;
    logic [SEL_W-1:0] thermo;

    // Count the set bits, then rebuild the thermometer pattern of that
    // length. The code is valid only if it equals the rebuilt pattern.
    always_comb begin
        ones = '0;
        for (int i = 0; i < SEL_W; i++) begin
            ones = ones + EXP_W'(code[i]);
        end
        for (int i = 0; i < SEL_W; i++) begin
            thermo[i] = (i < int'(ones));
        end
        invalid  = (thermo != code);
        exponent = invalid ? EXP_W'(SEL_W) : ones;
    end

endmodule

// File: rtl/rclk_refmux.sv
module rclk_refmux (
    input  logic use_int,
    input  logic int_tick,
    input  logic ext_tick,
    output logic sel_tick
);

    // Both references are strobes in one clock domain, so a plain mux
    // cannot glitch a clock.
    assign sel_tick = use_int ? int_tick : ext_tick;

endmodule

// File: rtl/rclk_seq.sv
module rclk_seq
    import rclk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_changed,
    output logic cnt_clear,
    output logic cnt_run
);

    seq_state_t state_q, state_d;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: if (!cfg_changed) state_d = ST_RUN;
            ST_RUN:  if (cfg_changed)  state_d = ST_HOLD;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    // Outputs.
    always_comb begin
        cnt_clear = 1'b0;
        cnt_run   = 1'b0;
        unique case (state_q)
            ST_HOLD: cnt_clear = 1'b1;
            ST_RUN: begin
                cnt_clear = cfg_changed;
                cnt_run   = !cfg_changed;
            end
        endcase
    end

endmodule

// File: rtl/rclk_divider.sv
module rclk_divider #(
    parameter int CNT_W = 4,
    parameter int EXP_W = $clog2(CNT_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic             tick,
    input  logic [EXP_W-1:0] exponent,
    output logic             rate_en,
    output logic             rate_clk
);

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] wrap_val;
    logic             at_wrap;

    // The terminal count is 2^exponent - 1, built as a mask of low ones.
    always_comb begin
        for (int i = 0; i < CNT_W; i++) begin
            wrap_val[i] = (i < int'(exponent));
        end
        at_wrap = (count_q == wrap_val);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            rate_en <= 1'b0;
        end else if (clear) begin
            count_q <= '0;
            rate_en <= 1'b0;
        end else if (run && tick) begin
            if (at_wrap) begin
                count_q <= '0;
                rate_en <= 1'b1;
            end else begin
                count_q <= count_q + 1'b1;
                rate_en <= 1'b0;
            end
        end else begin
            rate_en <= 1'b0;
        end
    end

    // The top bit of the active count range gives a 50% square wave.
    // At unity ratio the clock is held high.
    always_comb begin
        rate_clk = (exponent == '0);
        for (int i = 0; i < CNT_W; i++) begin
            if (int'(exponent) == i + 1) rate_clk = count_q[i];
        end
    end

endmodule

// File: rtl/rclk_rate_gen.sv
module rclk_rate_gen #(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             use_int_ref,
    input  logic             int_ref_tick,
    input  logic             ext_ref_tick,
    input  logic [SEL_W-1:0] rate_code,
    output logic             rate_en,
    output logic             rate_clk,
    output logic             config_error
);

    localparam int EXP_W = $clog2(SEL_W + 1);

    logic [EXP_W-1:0] exponent;
    logic             code_bad;
    logic             sel_tick;
    logic             cfg_changed;
    logic             cnt_clear;
    logic             cnt_run;
    logic [SEL_W-1:0] prev_code_q;
    logic             prev_src_q;

    rclk_decode #(.SEL_W(SEL_W), .EXP_W(EXP_W)) u_decode (
        .code     (rate_code),
        .exponent (exponent),
        .invalid  (code_bad)
    );

    rclk_refmux u_refmux (
        .use_int  (use_int_ref),
        .int_tick (int_ref_tick),
        .ext_tick (ext_ref_tick),
        .sel_tick (sel_tick)
    );

    // Configuration tracking: remember the last sampled selection and
    // register the error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_code_q  <= '0;
            prev_src_q   <= 1'b0;
            config_error <= 1'b0;
        end else begin
            prev_code_q  <= rate_code;
            prev_src_q   <= use_int_ref;
            config_error <= code_bad;
        end
    end

    assign cfg_changed = (rate_code != prev_code_q) || (use_int_ref != prev_src_q);

    rclk_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_changed (cfg_changed),
        .cnt_clear   (cnt_clear),
        .cnt_run     (cnt_run)
    );

    rclk_divider #(.CNT_W(SEL_W), .EXP_W(EXP_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (cnt_clear),
        .run      (cnt_run),
        .tick     (sel_tick),
        .exponent (exponent),
        .rate_en  (rate_en),
        .rate_clk (rate_clk)
    );

endmodule

// File: rtl/rclk_rate_gen_chk.sv
module rclk_rate_gen_chk #(
    parameter int SEL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             use_int_ref,
    input logic             int_ref_tick,
    input logic             ext_ref_tick,
    input logic [SEL_W-1:0] rate_code,
    input logic             rate_en,
    input logic             rate_clk,
    input logic             config_error
);

    // A thermometer code plus one is a power of two (or wraps to zero).
    logic thermo_ok;
    always_comb thermo_ok = (((rate_code + 1'b1) & rate_code) == '0);

    p_en_after_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rate_en |-> $past(use_int_ref ? int_ref_tick : ext_ref_tick));

    p_no_en_after_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_code != $past(rate_code) || use_int_ref != $past(use_int_ref)) |=> !rate_en);

    p_error_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (config_error == !$past(thermo_ok)));

    p_unity_clk_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_code == '0) |-> rate_clk);

    p_wrap_clk_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_en && rate_code != '0) |-> !rate_clk);

endmodule

bind rclk_rate_gen rclk_rate_gen_chk #(.SEL_W(SEL_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .use_int_ref  (use_int_ref),
    .int_ref_tick (int_ref_tick),
    .ext_ref_tick (ext_ref_tick),
    .rate_code    (rate_code),
    .rate_en      (rate_en),
    .rate_clk     (rate_clk),
    .config_error (config_error)
);

// File: tb/test_rclk_rate_gen.sv
module test_rclk_rate_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       use_int_ref = 1'b1;
    logic       int_ref_tick = 1'b0;
    logic       ext_ref_tick = 1'b0;
    logic [3:0] rate_code = 4'b1111;
    logic       rate_en;
    logic       rate_clk;
    logic       config_error;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rclk_rate_gen #(.SEL_W(4)) i_rclk_rate_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .use_int_ref  (use_int_ref),
        .int_ref_tick (int_ref_tick),
        .ext_ref_tick (ext_ref_tick),
        .rate_code    (rate_code),
        .rate_en      (rate_en),
        .rate_clk     (rate_clk),
        .config_error (config_error)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic apply_cfg(input logic [3:0] code, input logic src);
        @(negedge clk);
        rate_code   = code;
        use_int_ref = src;
        repeat (3) @(negedge clk);
    endtask

    // Pulse one tick line; return at the next negedge with outputs settled.
    task automatic pulse(input logic on_int);
        @(negedge clk);
        if (on_int) int_ref_tick = 1'b1;
        else        ext_ref_tick = 1'b1;
        @(negedge clk);
        int_ref_tick = 1'b0;
        ext_ref_tick = 1'b0;
    endtask

    function automatic logic exp_clk(input int k, input int n);
        if (n == 1) return 1'b1;
        return ((k % n) >= n / 2);
    endfunction

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R8", "rate_en in reset", rate_en, 1'b0);
        chk("R8", "rate_clk in reset", rate_clk, 1'b0);
        chk("R8", "config_error in reset", config_error, 1'b0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_rate(input logic [3:0] code, input logic src, input int e,
                          input logic err, input int nticks);
        int n = 1 << e;
        int k = 0;
        apply_cfg(code, src);
        chk("R6", $sformatf("config_error code %b", code), config_error, err);
        for (int i = 0; i < nticks; i++) begin
            pulse(src);
            k++;
            chk("R1 R3", $sformatf("rate_en code %b tick %0d", code, k), rate_en, (k % n) == 0);
            chk("R4 R5", $sformatf("rate_clk code %b tick %0d", code, k), rate_clk, exp_clk(k, n));
            @(negedge clk);
            chk("R3", "rate_en one cycle wide", rate_en, 1'b0);
            if (i % 3 == 1) begin
                pulse(!src);
                chk("R2", "unselected tick gives no enable", rate_en, 1'b0);
                chk("R2", "unselected tick keeps rate_clk", rate_clk, exp_clk(k, n));
            end
        end
    endtask

    task automatic t_restart();
        apply_cfg(4'b0111, 1'b1);
        repeat (5) pulse(1'b1);
        // Change code together with a tick: that tick must be ignored.
        @(negedge clk);
        rate_code    = 4'b0011;
        int_ref_tick = 1'b1;
        @(negedge clk);
        int_ref_tick = 1'b0;
        chk("R7", "no enable after code change", rate_en, 1'b0);
        chk("R7", "counter cleared after code change", rate_clk, 1'b0);
        repeat (2) @(negedge clk);
        for (int k = 1; k <= 4; k++) begin
            pulse(1'b1);
            chk("R7", $sformatf("enable after restart tick %0d", k), rate_en, k == 4);
            chk("R7", $sformatf("rate_clk after restart tick %0d", k), rate_clk, exp_clk(k, 4));
        end
        // Source change mid-period restarts the count too.
        repeat (2) pulse(1'b1);
        @(negedge clk);
        use_int_ref = 1'b0;
        @(negedge clk);
        chk("R7", "counter cleared after source change", rate_clk, 1'b0);
        repeat (2) @(negedge clk);
        for (int k = 1; k <= 4; k++) begin
            pulse(1'b0);
            chk("R7", $sformatf("enable after source restart tick %0d", k), rate_en, k == 4);
        end
    endtask

    initial begin
        t_reset();
        t_rate(4'b0000, 1'b1, 0, 1'b0, 4);
        t_rate(4'b0001, 1'b1, 1, 1'b0, 6);
        t_rate(4'b0011, 1'b0, 2, 1'b0, 8);
        t_rate(4'b0111, 1'b1, 3, 1'b0, 16);
        t_rate(4'b1111, 1'b0, 4, 1'b0, 32);
        t_rate(4'b0010, 1'b1, 4, 1'b1, 16);
        t_rate(4'b1010, 1'b0, 4, 1'b1, 16);
        t_rate(4'b0001, 1'b0, 1, 1'b0, 4);
        t_restart();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule